// File: doc/BRIEF.md
# Active Priority Bitmap Tracker

This block records which preemption levels are currently active on a virtual interrupt interface. It keeps one bitmap for group 0 and one for group 1. Each bitmap holds up to four 32-bit words. Its configuration input gives the number of implemented preemption bits. From that count the block derives a minimum binary point and the number of words in use. It also holds the two per-group binary-point values and a flag that makes group 1 share the group-0 binary point.

On an acknowledge, the priority is masked down to its preemption level using the group's binary point. The level is rescaled by the minimum binary point, and the matching bitmap bit is set. The running priority is always visible as a combinational output. An end-of-interrupt request clears the single highest active level and reports that level in the same cycle. Software-style direct access lets any bitmap word be read or overwritten.

Top module: `apt_tracker`

## Requirements
- R1: After reset both bitmaps are empty, the running priority reads 0xFF, the group-0 binary point reads 2, the group-1 binary point reads 3 and the shared-binary-point flag reads 0.
- R2: The configuration code c gives n = c+1 preemption bits, limited to the range 5..7. The minimum binary point is 8−n and the number of words in use is 1<<(n−5). Word indices at or above that number read as 0, and writes to them are ignored.
- R3: An accepted mark request takes a priority p and a group g. It forms the preemption level p & (0xFF << s), where s is the group-0 binary point plus one for group 0 and the effective group-1 binary point for group 1. It then sets bit (level >> minimum binary point) of that group's bitmap, in word index/32 at bit index%32, visible from the next cycle.
- R4: While the shared flag is 1, the effective group-1 binary point equals the group-0 binary point plus one, saturating at 7, and group-1 binary-point writes leave the stored value unchanged.
- R5: A group-0 binary-point write stores the larger of the written value and the minimum binary point minus one. A group-1 write, when allowed, stores the larger of the written value and the minimum binary point.
- R6: The running priority is found from the lowest word in use whose OR of both groups is non-zero. It equals (32×word + lowest set bit of that OR) shifted left by the minimum binary point, and it is 0xFF when no bit is set.
- R7: An accepted drop clears one bit in the first non-empty word pair. The group-0 bit is cleared only when its lowest set position is strictly lower than group 1's. Otherwise, including a tie, the group-1 bit is cleared.
- R8: An accepted drop raises drop_ack and shows the dropped level on drop_prio in the same cycle, equal to the running priority before the clear. A drop on empty bitmaps returns 0xFF and changes nothing. drop_prio reads 0xFF when no drop is accepted.
- R9: When two or more of mark, drop and word write are requested in one cycle, req_reject is 1, none of them takes effect and drop_ack stays 0.
- R10: A word write replaces the addressed word of the chosen group from the next cycle, and word_rdata shows the addressed word combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_pre_code | input | 3 | Preemption-bit configuration code (bits = code+1, limited to 5..7) |
| bp_wr_en | input | 1 | Binary-point write strobe |
| bp_wr_grp | input | 1 | Binary-point write target group |
| bp_wr_val | input | 3 | Binary-point write value |
| cbpr_wr_en | input | 1 | Shared-binary-point flag write strobe |
| cbpr_wr_val | input | 1 | Shared-binary-point flag value |
| bp0_o | output | 3 | Group-0 binary point |
| bp1_o | output | 3 | Effective group-1 binary point |
| cbpr_o | output | 1 | Shared-binary-point flag |
| act_set | input | 1 | Mark a priority active |
| act_grp | input | 1 | Group of the mark request |
| act_prio | input | 8 | Priority to mark |
| drop_req | input | 1 | Drop the highest active priority |
| drop_ack | output | 1 | Drop accepted this cycle |
| drop_prio | output | 8 | Level dropped this cycle, 0xFF if none |
| rpr_o | output | 8 | Running (highest active) priority |
| word_wr_en | input | 1 | Direct word write strobe |
| word_wr_grp | input | 1 | Direct write group |
| word_wr_idx | input | 2 | Direct write word index |
| word_wdata | input | 32 | Direct write data |
| word_rd_grp | input | 1 | Direct read group |
| word_rd_idx | input | 2 | Direct read word index |
| word_rdata | output | 32 | Direct read data |
| req_reject | output | 1 | Conflicting requests rejected this cycle |

## Verification
The hardest case to reach from the ports is a drop where both groups hold a bit at the same position in the same word. That tie must clear the group-1 bit, and a neighbouring case with group 0 one position lower must clear the group-0 bit. Random priorities rarely line up like this. Directed sequences therefore mark the same priority in both groups, and a second sequence places group 0 just below. The bench then reads each word back after every drop. Long random runs under all three preemption-bit settings mix marks, drops, clamped binary-point writes, flag toggles, word overwrites and deliberate conflicts. Each step is compared against a bench-side model of both bitmaps.

// File: rtl/apt_pkg.sv
// Shared constants and helpers for the active priority tracker.
// Assumes a 32-bit bitmap word and an 8-bit priority.
package apt_pkg;
    localparam int APT_PRIO_W    = 8;
    localparam int APT_WORD_W    = 32;
    localparam int APT_MAX_WORDS = 4;
    localparam int APT_BIT_W     = $clog2(APT_WORD_W);

    typedef enum logic {
        APT_GRP0 = 1'b0,
        APT_GRP1 = 1'b1
    } apt_grp_e;

    // Position of the lowest set bit, or APT_WORD_W when the word is zero.
    function automatic logic [APT_BIT_W:0] lowest_set(input logic [APT_WORD_W-1:0] v);
        logic [APT_BIT_W:0] r;
        r = (APT_BIT_W+1)'(APT_WORD_W);
        for (int i = APT_WORD_W - 1; i >= 0; i--) begin
            if (v[i]) r = (APT_BIT_W+1)'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/apt_binpoint.sv
// Binary-point state for both groups plus the shared-binary-point flag.
// Clamps writes to the minimum binary point and turns a priority into a
// preemption level. Assumes mbp_i (1..3) only changes while in reset.
module apt_binpoint
    import apt_pkg::*;
#(
    parameter int PRIO_W  = APT_PRIO_W,
    parameter int BP0_RST = 2,
    parameter int BP1_RST = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mbp_i,
    input  logic              bp_wr_en,
    input  logic              bp_wr_grp,
    input  logic [2:0]        bp_wr_val,
    input  logic              cbpr_wr_en,
    input  logic              cbpr_wr_val,
    input  logic [PRIO_W-1:0] prio_i,
    input  logic              grp_i,
    output logic [2:0]        bp0_o,
    output logic [2:0]        bp1_eff_o,
    output logic              cbpr_o,
    output logic [PRIO_W-1:0] pre_lvl_o
);
    localparam int MASK_W = 2 * PRIO_W;

    logic [2:0]        bp0_q, bp1_q;
    logic              cbpr_q;
    logic [2:0]        floor0, floor1;
    logic [3:0]        shift;
    logic [MASK_W-1:0] mask_wide;

    // Lowest legal stored value for each group.
    always_comb begin
        floor0 = mbp_i - 3'd1;
        floor1 = mbp_i;
    end

    // Binary-point registers with clamping and the shared-flag write guard.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp0_q  <= 3'(BP0_RST);
            bp1_q  <= 3'(BP1_RST);
            cbpr_q <= 1'b0;
        end else begin
            if (bp_wr_en && bp_wr_grp == APT_GRP0)
                bp0_q <= (bp_wr_val < floor0) ? floor0 : bp_wr_val;
            if (bp_wr_en && bp_wr_grp == APT_GRP1 && !cbpr_q)
                bp1_q <= (bp_wr_val < floor1) ? floor1 : bp_wr_val;
            if (cbpr_wr_en)
                cbpr_q <= cbpr_wr_val;
        end
    end

    // Effective group-1 point and the preemption mask for the request.
    always_comb begin
        bp1_eff_o = cbpr_q ? ((bp0_q == 3'd7) ? 3'd7 : bp0_q + 3'd1) : bp1_q;
        shift     = (grp_i == APT_GRP1) ? {1'b0, bp1_eff_o} : {1'b0, bp0_q} + 4'd1;
        mask_wide = MASK_W'({PRIO_W{1'b1}}) << shift;
        pre_lvl_o = prio_i & mask_wide[PRIO_W-1:0];
        bp0_o     = bp0_q;
        cbpr_o    = cbpr_q;
    end

    // R5
    bp0_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp0_q >= floor0);
    // R5
    bp1_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp1_q >= floor1);
    // R4
    bp1_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cbpr_q |=> bp1_q == $past(bp1_q));
endmodule

// File: rtl/apt_scan.sv
// Joint scan of both group bitmaps. Finds the first non-empty word pair in
// use, picks the bit to clear (group 1 on a tie) and forms the rescaled level.
// Purely combinational.
module apt_scan
    import apt_pkg::*;
#(
    parameter int WORD_W    = APT_WORD_W,
    parameter int MAX_WORDS = APT_MAX_WORDS,
    parameter int PRIO_W    = APT_PRIO_W,
    localparam int WIDX_W   = $clog2(MAX_WORDS),
    localparam int BIT_W    = $clog2(WORD_W)
) (
    input  logic [MAX_WORDS-1:0][WORD_W-1:0] map0_i,
    input  logic [MAX_WORDS-1:0][WORD_W-1:0] map1_i,
    input  logic [WIDX_W:0]                  nwords_i,
    input  logic [2:0]                       mbp_i,
    output logic                             found_o,
    output logic [WIDX_W-1:0]                hit_word_o,
    output logic [BIT_W-1:0]                 hit_bit_o,
    output logic                             clr_grp1_o,
    output logic [PRIO_W-1:0]                level_o
);
    localparam int IDX_W = WIDX_W + BIT_W;

    logic [MAX_WORDS-1:0]            nz;
    logic [MAX_WORDS-1:0][BIT_W:0]   c0, c1;
    logic [BIT_W:0]                  c0s, c1s;
    logic [PRIO_W:0]                 lvl_wide;

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_word
        // Per-word emptiness and lowest positions in each group.
        always_comb begin
            nz[w] = (32'(w) < 32'(nwords_i)) && (|(map0_i[w] | map1_i[w]));
            c0[w] = lowest_set(map0_i[w]);
            c1[w] = lowest_set(map1_i[w]);
        end
    end

    // Lowest non-empty word wins; within it, group 0 only if strictly lower.
    always_comb begin
        found_o    = 1'b0;
        hit_word_o = '0;
        for (int w = MAX_WORDS - 1; w >= 0; w--) begin
            if (nz[w]) begin
                found_o    = 1'b1;
                hit_word_o = WIDX_W'(w);
            end
        end
        c0s        = c0[hit_word_o];
        c1s        = c1[hit_word_o];
        clr_grp1_o = !(c0s < c1s);
        hit_bit_o  = clr_grp1_o ? c1s[BIT_W-1:0] : c0s[BIT_W-1:0];
        lvl_wide   = (PRIO_W+1)'(IDX_W'({hit_word_o, hit_bit_o})) << mbp_i;
        level_o    = found_o ? lvl_wide[PRIO_W-1:0] : {PRIO_W{1'b1}};
    end
endmodule

// File: rtl/apt_tracker.sv
// Active priority bitmap tracker. Holds the group-0 and group-1 bitmaps,
// accepts mark / drop / direct word write requests (one per cycle) and
// reports the running priority. Assumes cfg_pre_code is static outside reset.
module apt_tracker
    import apt_pkg::*;
#(
    parameter int WORD_W    = APT_WORD_W,
    parameter int MAX_WORDS = APT_MAX_WORDS,
    parameter int PRIO_W    = APT_PRIO_W,
    localparam int WIDX_W   = $clog2(MAX_WORDS),
    localparam int BIT_W    = $clog2(WORD_W),
    localparam int IDX_W    = WIDX_W + BIT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_pre_code,
    input  logic              bp_wr_en,
    input  logic              bp_wr_grp,
    input  logic [2:0]        bp_wr_val,
    input  logic              cbpr_wr_en,
    input  logic              cbpr_wr_val,
    output logic [2:0]        bp0_o,
    output logic [2:0]        bp1_o,
    output logic              cbpr_o,
    input  logic              act_set,
    input  logic              act_grp,
    input  logic [PRIO_W-1:0] act_prio,
    input  logic              drop_req,
    output logic              drop_ack,
    output logic [PRIO_W-1:0] drop_prio,
    output logic [PRIO_W-1:0] rpr_o,
    input  logic              word_wr_en,
    input  logic              word_wr_grp,
    input  logic [WIDX_W-1:0] word_wr_idx,
    input  logic [WORD_W-1:0] word_wdata,
    input  logic              word_rd_grp,
    input  logic [WIDX_W-1:0] word_rd_idx,
    output logic [WORD_W-1:0] word_rdata,
    output logic              req_reject
);
    logic [MAX_WORDS-1:0][WORD_W-1:0] map0_q, map1_q;
    logic [2:0]        n_pre, mbp;
    logic [WIDX_W:0]   nwords;
    logic [1:0]        n_ops;
    logic              set_ok, drop_ok, wr_ok;
    logic [PRIO_W-1:0] pre_lvl;
    logic [IDX_W-1:0]  set_idx;
    logic [WIDX_W-1:0] set_word;
    logic [BIT_W-1:0]  set_bit;
    logic              found, clr_grp1;
    logic [WIDX_W-1:0] hit_word;
    logic [BIT_W-1:0]  hit_bit;
    logic [PRIO_W-1:0] level;

    // Decode the preemption-bit count, minimum binary point and word count.
    always_comb begin
        if (cfg_pre_code < 3'd4)      n_pre = 3'd5;
        else if (cfg_pre_code > 3'd6) n_pre = 3'd7;
        else                          n_pre = cfg_pre_code + 3'd1;
        mbp    = 3'd0 - n_pre;
        nwords = (WIDX_W+1)'(1) << (n_pre - 3'd5);
    end

    apt_binpoint #(.PRIO_W(PRIO_W)) u_bp (
        .clk         (clk),
        .rst_n       (rst_n),
        .mbp_i       (mbp),
        .bp_wr_en    (bp_wr_en),
        .bp_wr_grp   (bp_wr_grp),
        .bp_wr_val   (bp_wr_val),
        .cbpr_wr_en  (cbpr_wr_en),
        .cbpr_wr_val (cbpr_wr_val),
        .prio_i      (act_prio),
        .grp_i       (act_grp),
        .bp0_o       (bp0_o),
        .bp1_eff_o   (bp1_o),
        .cbpr_o      (cbpr_o),
        .pre_lvl_o   (pre_lvl)
    );

    apt_scan #(.WORD_W(WORD_W), .MAX_WORDS(MAX_WORDS), .PRIO_W(PRIO_W)) u_scan (
        .map0_i     (map0_q),
        .map1_i     (map1_q),
        .nwords_i   (nwords),
        .mbp_i      (mbp),
        .found_o    (found),
        .hit_word_o (hit_word),
        .hit_bit_o  (hit_bit),
        .clr_grp1_o (clr_grp1),
        .level_o    (level)
    );

    // Request arbitration: more than one bitmap operation rejects them all.
    always_comb begin
        n_ops      = 2'(act_set) + 2'(drop_req) + 2'(word_wr_en);
        req_reject = n_ops > 2'd1;
        set_ok     = act_set && !req_reject;
        drop_ok    = drop_req && !req_reject;
        wr_ok      = word_wr_en && !req_reject
                     && ({1'b0, word_wr_idx} < nwords);
        set_idx    = IDX_W'(pre_lvl >> mbp);
        set_word   = set_idx[IDX_W-1:BIT_W];
        set_bit    = set_idx[BIT_W-1:0];
        drop_ack   = drop_ok;
        drop_prio  = drop_ok ? level : {PRIO_W{1'b1}};
        rpr_o      = level;
        word_rdata = ({1'b0, word_rd_idx} < nwords)
                     ? (word_rd_grp ? map1_q[word_rd_idx] : map0_q[word_rd_idx])
                     : '0;
    end

    for (genvar w = 0; w < MAX_WORDS; w++) begin : g_map
        // One word of each group: overwrite, mark or drop this word.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                map0_q[w] <= '0;
                map1_q[w] <= '0;
            end else begin
                if (wr_ok && word_wr_idx == WIDX_W'(w)) begin
                    if (word_wr_grp) map1_q[w] <= word_wdata;
                    else             map0_q[w] <= word_wdata;
                end
                if (set_ok && set_word == WIDX_W'(w)) begin
                    if (act_grp) map1_q[w][set_bit] <= 1'b1;
                    else         map0_q[w][set_bit] <= 1'b1;
                end
                if (drop_ok && found && hit_word == WIDX_W'(w)) begin
                    if (clr_grp1) map1_q[w][hit_bit] <= 1'b0;
                    else          map0_q[w][hit_bit] <= 1'b0;
                end
            end
        end
    end

    logic [15:0] ones_total;
    always_comb ones_total = 16'($countones(map0_q)) + 16'($countones(map1_q));

    // R9
    reject_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reject |=> (map0_q == $past(map0_q)) && (map1_q == $past(map1_q)));
    // R7
    drop_one_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_ack && found) |=> ones_total == $past(ones_total) - 16'd1);
    // R3
    mark_raises_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_set && !req_reject) |=> rpr_o <= $past(pre_lvl));
    // R6
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rpr_o == {PRIO_W{1'b1}}) == (ones_total == 16'd0));
endmodule

// File: tb/tb_apt_tracker.sv
`timescale 1ns/1ps
module tb_apt_tracker;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [2:0]  cfg_pre_code = 3'd6;
    logic        bp_wr_en = 0, bp_wr_grp = 0, cbpr_wr_en = 0, cbpr_wr_val = 0;
    logic [2:0]  bp_wr_val = 0;
    logic [2:0]  bp0_o, bp1_o;
    logic        cbpr_o;
    logic        act_set = 0, act_grp = 0, drop_req = 0, drop_ack;
    logic [7:0]  act_prio = 0, drop_prio, rpr_o;
    logic        word_wr_en = 0, word_wr_grp = 0, word_rd_grp = 0, req_reject;
    logic [1:0]  word_wr_idx = 0, word_rd_idx = 0;
    logic [31:0] word_wdata = 0, word_rdata;

    apt_tracker dut (
        .clk(clk), .rst_n(rst_n), .cfg_pre_code(cfg_pre_code),
        .bp_wr_en(bp_wr_en), .bp_wr_grp(bp_wr_grp), .bp_wr_val(bp_wr_val),
        .cbpr_wr_en(cbpr_wr_en), .cbpr_wr_val(cbpr_wr_val),
        .bp0_o(bp0_o), .bp1_o(bp1_o), .cbpr_o(cbpr_o),
        .act_set(act_set), .act_grp(act_grp), .act_prio(act_prio),
        .drop_req(drop_req), .drop_ack(drop_ack), .drop_prio(drop_prio),
        .rpr_o(rpr_o), .word_wr_en(word_wr_en), .word_wr_grp(word_wr_grp),
        .word_wr_idx(word_wr_idx), .word_wdata(word_wdata),
        .word_rd_grp(word_rd_grp), .word_rd_idx(word_rd_idx),
        .word_rdata(word_rdata), .req_reject(req_reject)
    );

    int checks = 0, errors = 0;
    logic [31:0] m0 [4];
    logic [31:0] m1 [4];
    int bp0, bp1;
    bit cb;
    // pending stimulus for the next step
    bit p_set, p_grp, p_drop, p_ww, p_wg, p_bw, p_bg, p_cw, p_cv, p_rg;
    int p_prio, p_wi, p_bv, p_ri;
    logic [31:0] p_wd;
    logic [7:0]  o_dp;
    logic [31:0] o_rd;

    function automatic int f_nb();
        int c = int'(cfg_pre_code);
        return (c < 4) ? 5 : ((c > 6) ? 7 : c + 1);
    endfunction
    function automatic int f_mbp(); return 8 - f_nb(); endfunction
    function automatic int f_nw();  return 1 << (f_nb() - 5); endfunction
    function automatic int f_bp1e(); return cb ? ((bp0 == 7) ? 7 : bp0 + 1) : bp1; endfunction
    function automatic int f_pre(int p, bit g);
        int sh = g ? f_bp1e() : bp0 + 1;
        return p & ((32'hFF << sh) & 32'hFF);
    endfunction
    function automatic int f_low(logic [31:0] v);
        for (int i = 0; i < 32; i++) if (v[i]) return i;
        return 32;
    endfunction
    function automatic int f_rpr();
        for (int w = 0; w < f_nw(); w++)
            if ((m0[w] | m1[w]) != 0)
                return ((32 * w + f_low(m0[w] | m1[w])) << f_mbp()) & 255;
        return 255;
    endfunction
    function automatic void model_drop();
        for (int w = 0; w < f_nw(); w++) begin
            if ((m0[w] | m1[w]) != 0) begin
                int c0 = f_low(m0[w]);
                int c1 = f_low(m1[w]);
                if (c0 < c1) m0[w][c0] = 1'b0;
                else         m1[w][c1] = 1'b0;
                return;
            end
        end
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic clear_pend();
        p_set = 0; p_grp = 0; p_drop = 0; p_ww = 0; p_wg = 0; p_bw = 0;
        p_bg = 0; p_cw = 0; p_cv = 0; p_rg = 0;
        p_prio = 0; p_wi = 0; p_bv = 0; p_ri = 0; p_wd = 0;
    endtask

    task automatic step();
        bit rej;
        int pre, idx, ex_rd;
        @(negedge clk);
        act_set = p_set; act_grp = p_grp; act_prio = 8'(p_prio);
        drop_req = p_drop; word_wr_en = p_ww; word_wr_grp = p_wg;
        word_wr_idx = 2'(p_wi); word_wdata = p_wd; bp_wr_en = p_bw;
        bp_wr_grp = p_bg; bp_wr_val = 3'(p_bv); cbpr_wr_en = p_cw;
        cbpr_wr_val = p_cv; word_rd_grp = p_rg; word_rd_idx = 2'(p_ri);
        #1;
        rej = (int'(p_set) + int'(p_drop) + int'(p_ww)) > 1;
        chk("R9", "req_reject", 32'(req_reject), 32'(rej));
        chk("R8", "drop_ack", 32'(drop_ack), 32'(p_drop && !rej));
        chk("R8", "drop_prio", 32'(drop_prio), (p_drop && !rej) ? f_rpr() : 255);
        chk("R6", "rpr", 32'(rpr_o), f_rpr());
        chk("R5", "bp0", 32'(bp0_o), bp0);
        chk("R4", "bp1 effective", 32'(bp1_o), f_bp1e());
        chk("R4", "cbpr", 32'(cbpr_o), 32'(cb));
        ex_rd = (p_ri < f_nw()) ? (p_rg ? m1[p_ri] : m0[p_ri]) : 0;
        chk("R10", "word_rdata", word_rdata, ex_rd);
        o_dp = drop_prio; o_rd = word_rdata;
        @(posedge clk); #1;
        if (!rej) begin
            if (p_ww && p_wi < f_nw()) begin
                if (p_wg) m1[p_wi] = p_wd; else m0[p_wi] = p_wd;
            end
            if (p_set) begin
                pre = f_pre(p_prio, p_grp);
                idx = pre >> f_mbp();
                if (p_grp) m1[idx / 32][idx % 32] = 1'b1;
                else       m0[idx / 32][idx % 32] = 1'b1;
            end
            if (p_drop) model_drop();
        end
        if (p_bw) begin
            if (!p_bg) bp0 = (p_bv < f_mbp() - 1) ? f_mbp() - 1 : p_bv;
            else if (!cb) bp1 = (p_bv < f_mbp()) ? f_mbp() : p_bv;
        end
        if (p_cw) cb = p_cv;
        act_set = 0; drop_req = 0; word_wr_en = 0; bp_wr_en = 0; cbpr_wr_en = 0;
        clear_pend();
    endtask

    task automatic do_reset(int code);
        @(negedge clk);
        rst_n = 0;
        cfg_pre_code = 3'(code);
        repeat (3) @(negedge clk);
        rst_n = 1;
        for (int w = 0; w < 4; w++) begin m0[w] = 0; m1[w] = 0; end
        bp0 = 2; bp1 = 3; cb = 0;
        #1;
        // R1 reset state
        chk("R1", "rpr after reset", 32'(rpr_o), 255);
        chk("R1", "bp0 after reset", 32'(bp0_o), 2);
        chk("R1", "bp1 after reset", 32'(bp1_o), 3);
        chk("R1", "cbpr after reset", 32'(cbpr_o), 0);
    endtask

    task automatic rand_phase(int code, int n);
        do_reset(code);
        for (int k = 0; k < n; k++) begin
            int r = $urandom_range(99);
            clear_pend();
            if (r < 40) begin
                p_set = 1; p_grp = 1'($urandom); p_prio = $urandom_range(255);
            end else if (r < 62) p_drop = 1;
            else if (r < 72) begin
                p_bw = 1; p_bg = 1'($urandom); p_bv = $urandom_range(7);
            end else if (r < 77) begin
                p_cw = 1; p_cv = 1'($urandom);
            end else if (r < 82) begin
                p_ww = 1; p_wg = 1'($urandom); p_wi = $urandom_range(3);
                p_wd = $urandom & $urandom & $urandom;
            end else if (r < 88) begin
                p_set = 1; p_drop = 1'($urandom); p_ww = !p_drop;
                p_prio = $urandom_range(255); p_wi = $urandom_range(3); p_wd = $urandom;
            end
            p_rg = 1'($urandom); p_ri = $urandom_range(3);
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        clear_pend();

        // Directed: code 6 -> 7 bits, mbp 1, four words.
        do_reset(6);
        // R3: prio 0x40, shift 3 -> level 0x40, index 32 -> word 1 bit 0
        clear_pend(); p_set = 1; p_grp = 0; p_prio = 'h47; step();
        clear_pend(); p_set = 1; p_grp = 1; p_prio = 'h40; p_ri = 1; p_rg = 0; step();
        chk("R3", "group0 word1", o_rd, 32'h1);
        chk("R6", "rpr two-group tie", 32'(rpr_o), 'h40);
        // R7 tie: group 1 cleared first
        clear_pend(); p_drop = 1; step();
        chk("R8", "tie dropped level", 32'(o_dp), 'h40);
        clear_pend(); p_rg = 1; p_ri = 1; step();
        chk("R7", "tie clears group1", o_rd, 32'h0);
        clear_pend(); p_rg = 0; p_ri = 1; step();
        chk("R7", "tie keeps group0", o_rd, 32'h1);
        // R7 group 0 strictly lower: word0 bit3 (g0) vs bit4 (g1)
        clear_pend(); p_ww = 1; p_wg = 0; p_wi = 0; p_wd = 32'h8; step();
        clear_pend(); p_ww = 1; p_wg = 1; p_wi = 0; p_wd = 32'h10; step();
        clear_pend(); p_drop = 1; step();
        chk("R8", "strict dropped level", 32'(o_dp), 6);
        clear_pend(); p_rg = 0; p_ri = 0; step();
        chk("R7", "strict clears group0", o_rd, 32'h0);
        // drain and drop on empty
        repeat (2) begin clear_pend(); p_drop = 1; step(); end
        clear_pend(); p_drop = 1; step();
        chk("R8", "empty drop level", 32'(o_dp), 'hFF);
        // R9: conflicting mark and drop does nothing
        clear_pend(); p_set = 1; p_drop = 1; p_prio = 'h10; step();
        chk("R9", "rpr after reject", 32'(rpr_o), 'hFF);
        // R4: shared flag locks group-1 writes
        clear_pend(); p_cw = 1; p_cv = 1; step();
        clear_pend(); p_bw = 1; p_bg = 1; p_bv = 7; step();
        chk("R4", "bp1 follows bp0+1", 32'(bp1_o), 3);
        clear_pend(); p_cw = 1; p_cv = 0; step();
        chk("R4", "bp1 write ignored", 32'(bp1_o), 3);

        // Directed: code 2 -> clamped to 5 bits, mbp 3, one word.
        do_reset(2);
        clear_pend(); p_bw = 1; p_bg = 0; p_bv = 0; step();
        chk("R5", "bp0 clamp", 32'(bp0_o), 2);
        clear_pend(); p_bw = 1; p_bg = 1; p_bv = 1; step();
        chk("R5", "bp1 clamp", 32'(bp1_o), 3);
        clear_pend(); p_ww = 1; p_wg = 0; p_wi = 2; p_wd = 32'hFFFF; p_ri = 2; step();
        clear_pend(); p_ri = 2; step();
        chk("R2", "word beyond range reads 0", o_rd, 0);
        chk("R2", "word beyond range no level", 32'(rpr_o), 'hFF);

        rand_phase(4, 1500);
        rand_phase(5, 1500);
        rand_phase(6, 1500);
        rand_phase(7, 600);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule